// File: doc/BRIEF.md
# Round-Robin Message Transmit Credit Scheduler

This block decides which of several transmit queues sends its next multi-segment message and paces each segment against outbound credit from the link layer. A pointer walks the queues in a fixed circular order. When it lands on a queue with a pending message, the scheduler raises a credit request for that message's first segment. Each granted request hands one segment to the physical layer through a one-cycle issue strobe.

Two attempt budgets apply. A first segment that cannot win credit within its small budget gives up its turn, and the message stays pending for the next lap. Once the first segment has gone out, the message owns the scheduler. Every further segment gets a much larger budget. If a segment exhausts that budget, the whole message is abandoned with an abort completion code. A message that finishes writes a success code. The descriptor source uses the completion strobe and its queue index to retire the message.

Top module: `txcs_sched`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `cred_req`, `seg_issue` and `cmp_we` are low, and the pointer rests on queue 0.
- R2: In a scan cycle, if the pointed-at queue has `q_valid` low while some other queue is valid, the pointer moves to the next queue in the loop (index + 1, wrapping to 0) in that single cycle. If the pointed-at queue is valid, `cred_req` rises in the next cycle.
- R3: When no queue is valid, the scheduler issues no credit request and the pointer holds.
- R4: `seg_issue` is high exactly in the cycles where `cred_req` and `cred_gnt` are both high. `seg_qidx` names the queue being served, and `seg_first` is 1 during its first segment.
- R5: A first segment is requested for at most 256 consecutive cycles without a grant. After the 256th such cycle, `cred_req` drops, the pointer advances, and no completion is written.
- R6: A message that yielded on its first segment stays pending. When the pointer returns to its queue, the message restarts from its first segment (`seg_first` = 1) with a fresh 256-attempt budget.
- R7: Each segment after the first gets up to 65536 request cycles without a grant. The attempt count restarts from zero after every grant, so each segment has its own full budget.
- R8: If a later segment sees 65536 ungranted request cycles, the cycle after the last one carries `cmp_we` = 1 with `cmp_code` = 3'b111 for that queue. No further segment of that message is issued, and the pointer advances.
- R9: When the last segment is granted, the next cycle carries `cmp_we` = 1 with `cmp_code` = 3'b000 for that queue, and the pointer advances.
- R10: Once the first segment of a message has been issued, `cred_req` stays high with an unchanged `seg_qidx` until the message completes or is cancelled. No other queue is served in that time.
- R11: `cmp_we` is a single-cycle strobe. While it is high, `cmp_qidx` holds the queue index and `cmp_code` holds either 3'b000 or 3'b111. A segment count of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_valid | input | NQ | Per-queue pending-message flag |
| q_segs | input | NQ*SEG_W | Per-queue segment count of the head message, queue i at bits [i*SEG_W +: SEG_W] |
| cred_req | output | 1 | Outbound credit request |
| cred_gnt | input | 1 | Credit grant, same-cycle response to a request |
| seg_issue | output | 1 | Segment handed to the physical layer this cycle |
| seg_qidx | output | QW | Queue currently served |
| seg_first | output | 1 | Current segment is the first of its message |
| cmp_we | output | 1 | Completion write strobe |
| cmp_qidx | output | QW | Queue index of the completion |
| cmp_code | output | 3 | Completion code: 3'b000 success, 3'b111 cancelled |

## Verification
The bench goes after the exact budget edges. A first segment granted on its 256th attempt must still be sent, and a later segment granted on its 65536th attempt must survive. A design off by one at either edge would yield too early, or abort a message that was granted in time. The bench also runs a full later-segment timeout. A design that reused the small budget, skipped the abort code, or kept issuing segments would mismatch the reference model there. Retries after a yield are checked for a restart at the first segment rather than a resume mid-message. Sparse pseudo-random grants with several queues loaded expose any scheduler that leaves a message part-way or serves queues out of circular order.

// File: rtl/txcs_pkg.sv
package txcs_pkg;
  typedef enum logic {
    ST_SCAN = 1'b0,
    ST_REQ  = 1'b1
  } txcs_state_t;

  localparam logic [2:0] CODE_DONE  = 3'b000;
  localparam logic [2:0] CODE_ABORT = 3'b111;
endpackage

// File: rtl/txcs_rr_ptr.sv
module txcs_rr_ptr #(
  parameter int NQ = 4,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [QW-1:0] ptr
);
  logic [QW-1:0] ptr_q, ptr_nx, ptr_inc;

  generate
    if (NQ == (1 << QW)) begin : g_pow2
      assign ptr_inc = ptr_q + 1'b1;
    end else begin : g_wrap
      assign ptr_inc = (ptr_q == QW'(NQ - 1)) ? '0 : ptr_q + 1'b1;
    end
  endgenerate

  always_comb begin
    ptr_nx = ptr_q;
    if (adv) ptr_nx = ptr_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_nx;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/txcs_attempt_ctr.sv
module txcs_attempt_ctr #(
  parameter int FIRST_LIMIT = 256,
  parameter int LATER_LIMIT = 65536,
  localparam int MAXL = (LATER_LIMIT > FIRST_LIMIT) ? LATER_LIMIT : FIRST_LIMIT,
  localparam int CW   = (MAXL > 2) ? $clog2(MAXL) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  input  logic first,
  output logic exhausted
);
  localparam logic [CW-1:0] FIRST_LAST = CW'(FIRST_LIMIT - 1);
  localparam logic [CW-1:0] LATER_LAST = CW'(LATER_LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_nx;

  always_comb begin
    cnt_nx = cnt_q;
    if (clr)      cnt_nx = '0;
    else if (inc) cnt_nx = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  assign exhausted = first ? (cnt_q == FIRST_LAST) : (cnt_q == LATER_LAST);
endmodule

// File: rtl/txcs_seg_ctr.sv
module txcs_seg_ctr #(
  parameter int SEG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEG_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  logic [SEG_W-1:0] rem_q, rem_nx;

  always_comb begin
    rem_nx = rem_q;
    if (load)     rem_nx = load_val;
    else if (dec) rem_nx = rem_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_nx;
  end

  assign last = (rem_q <= SEG_W'(1));
endmodule

// File: rtl/txcs_sched.sv
module txcs_sched
  import txcs_pkg::*;
#(
  parameter int NQ          = 4,
  parameter int SEG_W       = 8,
  parameter int FIRST_LIMIT = 256,
  parameter int LATER_LIMIT = 65536,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NQ-1:0]       q_valid,
  input  logic [NQ*SEG_W-1:0] q_segs,
  output logic                cred_req,
  input  logic                cred_gnt,
  output logic                seg_issue,
  output logic [QW-1:0]       seg_qidx,
  output logic                seg_first,
  output logic                cmp_we,
  output logic [QW-1:0]       cmp_qidx,
  output logic [2:0]          cmp_code
);
  logic [SEG_W-1:0] segs_arr [NQ];

  genvar gi;
  generate
    for (gi = 0; gi < NQ; gi++) begin : g_unpack
      assign segs_arr[gi] = q_segs[gi*SEG_W +: SEG_W];
    end
  endgenerate

  txcs_state_t   state_q, state_nx;
  logic          first_q, first_nx;
  logic          cmp_we_q, cmp_we_nx;
  logic [QW-1:0] cmp_qidx_q;
  logic [2:0]    cmp_code_q, cmp_code_nx;

  logic [QW-1:0] ptr;
  logic start, skip, miss, give_up, grant_more, grant_last, adv;
  logic last_seg, exhausted;

  txcs_rr_ptr #(.NQ(NQ)) u_ptr (
    .clk(clk), .rst_n(rst_n), .adv(adv), .ptr(ptr)
  );

  txcs_seg_ctr #(.SEG_W(SEG_W)) u_seg (
    .clk(clk), .rst_n(rst_n), .load(start), .load_val(segs_arr[ptr]),
    .dec(grant_more), .last(last_seg)
  );

  txcs_attempt_ctr #(.FIRST_LIMIT(FIRST_LIMIT), .LATER_LIMIT(LATER_LIMIT)) u_att (
    .clk(clk), .rst_n(rst_n), .clr(start | grant_more),
    .inc(miss & ~exhausted), .first(first_q), .exhausted(exhausted)
  );

  assign cred_req  = (state_q == ST_REQ);
  assign seg_issue = cred_req & cred_gnt;
  assign seg_qidx  = ptr;
  assign seg_first = first_q;

  always_comb begin
    start      = (state_q == ST_SCAN) & q_valid[ptr];
    skip       = (state_q == ST_SCAN) & ~q_valid[ptr] & (|q_valid);
    miss       = cred_req & ~cred_gnt;
    give_up    = miss & exhausted;
    grant_last = seg_issue & last_seg;
    grant_more = seg_issue & ~last_seg;
    adv        = skip | grant_last | give_up;

    state_nx = state_q;
    if (start)                        state_nx = ST_REQ;
    else if (grant_last || give_up)   state_nx = ST_SCAN;

    first_nx = first_q;
    if (start)           first_nx = 1'b1;
    else if (grant_more) first_nx = 1'b0;

    cmp_we_nx   = grant_last | (give_up & ~first_q);
    cmp_code_nx = grant_last ? CODE_DONE : CODE_ABORT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_SCAN;
      first_q  <= 1'b0;
      cmp_we_q <= 1'b0;
    end else begin
      state_q  <= state_nx;
      first_q  <= first_nx;
      cmp_we_q <= cmp_we_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_qidx_q <= '0;
      cmp_code_q <= CODE_DONE;
    end else if (cmp_we_nx) begin
      cmp_qidx_q <= ptr;
      cmp_code_q <= cmp_code_nx;
    end
  end

  assign cmp_we   = cmp_we_q;
  assign cmp_qidx = cmp_qidx_q;
  assign cmp_code = cmp_code_q;
endmodule

// File: rtl/txcs_sched_chk.sv
module txcs_sched_chk #(
  parameter int NQ          = 4,
  parameter int FIRST_LIMIT = 256,
  parameter int LATER_LIMIT = 65536,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int RW = $clog2(LATER_LIMIT + 2) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NQ-1:0] q_valid,
  input logic          cred_req,
  input logic          cred_gnt,
  input logic          seg_issue,
  input logic [QW-1:0] seg_qidx,
  input logic          seg_first,
  input logic          cmp_we,
  input logic [QW-1:0] cmp_qidx,
  input logic [2:0]    cmp_code
);
  logic [RW-1:0] miss_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     miss_run <= '0;
    else if (cred_req && !cred_gnt) miss_run <= miss_run + 1'b1;
    else                            miss_run <= '0;
  end

  // R5
  first_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cred_req && seg_first) |-> (miss_run < RW'(FIRST_LIMIT)));

  // R7
  later_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cred_req |-> (miss_run < RW'(LATER_LIMIT)));

  // R8
  abort_after_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we && cmp_code == 3'b111) |-> $past(cred_req && !cred_gnt && !seg_first));

  // R9
  done_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we && cmp_code == 3'b000) |-> $past(seg_issue));

  // R11
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |-> (cmp_code == 3'b000 || cmp_code == 3'b111));

  // R11
  strobe_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |-> (cmp_qidx == $past(seg_qidx)));

  // R10
  hold_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cred_req && $past(cred_req)) |-> $stable(seg_qidx));

  // R3
  req_needs_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cred_req) |-> $past(|q_valid));
endmodule

bind txcs_sched txcs_sched_chk #(
  .NQ(NQ), .FIRST_LIMIT(FIRST_LIMIT), .LATER_LIMIT(LATER_LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .cred_req(cred_req),
  .cred_gnt(cred_gnt), .seg_issue(seg_issue), .seg_qidx(seg_qidx),
  .seg_first(seg_first), .cmp_we(cmp_we), .cmp_qidx(cmp_qidx), .cmp_code(cmp_code)
);

// File: tb/txcs_sched_test.sv
`timescale 1ns/1ps
module txcs_sched_test;
  localparam int NQ = 4;
  localparam int SEG_W = 8;
  localparam int FIRST_LIMIT = 256;
  localparam int LATER_LIMIT = 65536;
  localparam int QW = 2;
  localparam int WATCHDOG = 195000;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [NQ-1:0]       q_valid = '0;
  logic [NQ*SEG_W-1:0] q_segs = '0;
  logic                cred_gnt = 1'b0;
  logic                cred_req, seg_issue, seg_first, cmp_we;
  logic [QW-1:0]       seg_qidx, cmp_qidx;
  logic [2:0]          cmp_code;

  always #2.5 clk = ~clk;

  txcs_sched #(.NQ(NQ), .SEG_W(SEG_W), .FIRST_LIMIT(FIRST_LIMIT), .LATER_LIMIT(LATER_LIMIT)) uut (
    .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_segs(q_segs),
    .cred_req(cred_req), .cred_gnt(cred_gnt), .seg_issue(seg_issue),
    .seg_qidx(seg_qidx), .seg_first(seg_first), .cmp_we(cmp_we),
    .cmp_qidx(cmp_qidx), .cmp_code(cmp_code)
  );

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 0;

  int msgs [NQ][$];
  bit retried [NQ];
  int gmode = 1;
  int cmp_seen = 0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  bit m_req = 0;
  int m_ptr = 0, m_rem = 0, m_att = 0;
  bit m_first = 0;
  bit m_cwe = 0;
  int m_cq = 0, m_cc = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cycles);
    end
  endtask

  function automatic bit any_valid();
    for (int i = 0; i < NQ; i++) if (msgs[i].size() > 0) return 1;
    return 0;
  endfunction

  always @(negedge clk) begin
    cycles++;
    for (int i = 0; i < NQ; i++) begin
      q_valid[i] = (msgs[i].size() > 0);
      q_segs[i*SEG_W +: SEG_W] = (msgs[i].size() > 0) ? SEG_W'(msgs[i][0]) : '0;
    end
    if (!rst_n) begin
      cred_gnt = 1'b0;
      m_req = 0; m_ptr = 0; m_rem = 0; m_att = 0; m_first = 0;
      m_cwe = 0; m_cq = 0; m_cc = 0;
    end else begin
      int lim;
      bit g;
      lim = m_first ? FIRST_LIMIT : LATER_LIMIT;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (gmode)
        0: g = 0;
        1: g = 1;
        2: g = lfsr[0] & lfsr[5];
        3: g = m_first;
        default: g = (m_att == lim - 1);
      endcase
      cred_gnt = g;
      #1;
      chk(m_req ? (m_first ? "R5" : "R7") : (any_valid() ? "R2" : "R3"), "cred_req",
          int'(cred_req), int'(m_req));
      chk("R4", "seg_issue", int'(seg_issue), int'(m_req && g));
      if (m_req) begin
        chk("R10", "seg_qidx", int'(seg_qidx), m_ptr);
        chk(retried[m_ptr] ? "R6" : "R4", "seg_first", int'(seg_first), int'(m_first));
      end
      chk("R11", "cmp_we", int'(cmp_we), int'(m_cwe));
      if (m_cwe) begin
        chk("R11", "cmp_qidx", int'(cmp_qidx), m_cq);
        chk(m_cc == 7 ? "R8" : "R9", "cmp_code", int'(cmp_code), m_cc);
      end
      if (cmp_we) cmp_seen++;
      // model step
      m_cwe = 0;
      if (!m_req) begin
        if (msgs[m_ptr].size() > 0) begin
          m_req = 1; m_rem = msgs[m_ptr][0]; m_att = 0; m_first = 1;
        end else if (any_valid()) begin
          m_ptr = (m_ptr + 1) % NQ;
        end
      end else if (g) begin
        if (m_rem <= 1) begin
          m_cwe = 1; m_cq = m_ptr; m_cc = 0;
          void'(msgs[m_ptr].pop_front()); retried[m_ptr] = 0;
          m_ptr = (m_ptr + 1) % NQ; m_req = 0;
        end else begin
          m_rem--; m_att = 0; m_first = 0;
        end
      end else if (m_att == lim - 1) begin
        if (!m_first) begin
          m_cwe = 1; m_cq = m_ptr; m_cc = 7;
          void'(msgs[m_ptr].pop_front()); retried[m_ptr] = 0;
        end else begin
          retried[m_ptr] = 1;
        end
        m_ptr = (m_ptr + 1) % NQ; m_req = 0;
      end else begin
        m_att++;
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog expired: actual %0d expected <= %0d cycles", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    gmode = 1;
    run(4);
    @(negedge clk); #2;
    // R1: outputs quiet during reset
    chk("R1", "cred_req in reset", int'(cred_req), 0);
    chk("R1", "cmp_we in reset", int'(cmp_we), 0);
    chk("R1", "seg_issue in reset", int'(seg_issue), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    // idle: R3
    run(20);
    // plain round robin, always granted
    msgs[0].push_back(3); msgs[0].push_back(1);
    msgs[2].push_back(1);
    msgs[3].push_back(2);
    run(40);
    // sparse grants, several queues
    gmode = 2;
    msgs[1].push_back(4); msgs[2].push_back(2); msgs[2].push_back(3); msgs[0].push_back(1);
    msgs[3].push_back(5);
    run(300);
    // first-segment yields (R5) then retry (R6)
    gmode = 0;
    msgs[1].push_back(2); msgs[3].push_back(1);
    cmp_seen = 0;
    run(700);
    chk("R5", "completions during first-segment yields", cmp_seen, 0);
    gmode = 1;
    run(40);
    chk("R6", "yielded messages finished after retry", msgs[1].size() + msgs[3].size(), 0);
    // grant on the final allowed attempt of each budget (R5, R7)
    gmode = 4;
    msgs[2].push_back(2); msgs[0].push_back(1);
    run(LATER_LIMIT + 2 * FIRST_LIMIT + 200);
    chk("R7", "boundary-granted messages completed", msgs[2].size() + msgs[0].size(), 0);
    // later-segment timeout (R8)
    gmode = 3;
    msgs[1].push_back(3);
    cmp_seen = 0;
    run(LATER_LIMIT + 100);
    chk("R8", "abort completion count", cmp_seen, 1);
    gmode = 1;
    msgs[1].push_back(1);
    run(30);
    chk("R9", "queues drained", int'(any_valid()), 0);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule